// File: doc/BRIEF.md
# Reed-Solomon Codeword Stream Framer

This block turns a plain stream of 8-bit message symbols into packets for a (255,223) Reed-Solomon encoder that takes framed input. It marks the first and the last of every 223 accepted symbols with start and end flags. After the last one it stalls the source for 32 clock slots. In those slots the encoder appends its check symbols, so the encoder never has to push back.

A position counter spans a whole 255-slot codeword. In the message part, slots 0 to 222, it moves forward only when a symbol is accepted. In the parity part, slots 223 to 254, it moves forward on every clock. After slot 254 it returns to 0, and the next packet starts only when the next symbol arrives. All outputs toward the encoder are registered together, so data and flags line up.

Top module: `rs_framer`

## Requirements
- R1: While rst_ni is low, and right after it, pos_o is 0, src_ready_o is 1, and enc_valid_o, enc_sop_o, enc_eop_o and enc_data_o are all 0.
- R2: A symbol accepted on a rising edge (src_valid_i and src_ready_o both 1) appears on enc_data_o with enc_valid_o = 1 right after that edge.
- R3: enc_sop_o is 1 only for the symbol accepted while pos_o was 0.
- R4: enc_eop_o is 1 only for the symbol accepted while pos_o was 222, which is the 223rd symbol of the packet.
- R5: In the message part (pos_o 0 to 222), an edge with src_valid_i = 0 leaves pos_o unchanged and drives enc_valid_o, enc_sop_o and enc_eop_o to 0.
- R6: src_ready_o is 0 exactly while pos_o is 223 to 254. In that window src_valid_i is ignored: enc_valid_o stays 0 and enc_data_o keeps the last accepted symbol.
- R7: In the parity part, pos_o steps by 1 on every edge, whatever src_valid_i is. From 254 it wraps to 0, which gives exactly 32 stalled slots.
- R8: After the wrap, pos_o stays at 0 and no start flag is issued until the next valid symbol arrives.
- R9: enc_sop_o and enc_eop_o are each 1 only together with enc_valid_o, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_data_i | input | 8 | Message symbol from the source |
| src_valid_i | input | 1 | Source symbol present |
| src_ready_o | output | 1 | Framer can take a symbol this cycle (low in parity slots) |
| enc_data_o | output | 8 | Registered symbol to the encoder |
| enc_valid_o | output | 1 | Registered symbol valid |
| enc_sop_o | output | 1 | First symbol of the packet |
| enc_eop_o | output | 1 | Last (223rd) symbol of the packet |
| pos_o | output | 8 | Current slot in the codeword, 0 to 254 |

## Verification
Every encoder-side output goes through exactly one register. So the result of an edge shows up right after that edge. src_ready_o and pos_o describe the state before the next edge. The bench drives inputs on the falling edge and samples shortly after the rising edge that takes them in. It checks src_ready_o and pos_o before each drive and the registered outputs after it. Parity-slot counting and the wrap are checked slot by slot over all 32 stalled edges, with the source both pushing and idle.

// File: rtl/rs_framer_pkg.sv
package rs_framer_pkg;
  typedef struct packed {
    logic valid;
    logic sop;
    logic eop;
  } frm_ctl_t;
endpackage

// File: rtl/rs_framer_pos_ctr.sv
module rs_framer_pos_ctr #(
  parameter int MSG_LEN = 223,
  parameter int CW_LEN  = 255,
  localparam int POS_W  = $clog2(CW_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  output logic [POS_W-1:0] pos_o,
  output logic             msg_phase_o
);
  localparam logic [POS_W-1:0] MSG_END = POS_W'(MSG_LEN - 1);
  localparam logic [POS_W-1:0] CW_END  = POS_W'(CW_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             step;

  assign msg_phase_o = (pos_q <= MSG_END);
  // parity slots run free, message slots wait for accepted symbols
  assign step        = msg_phase_o ? acc_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (step)     pos_q <= (pos_q == CW_END) ? '0 : pos_q + POS_W'(1);
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/rs_framer_out_reg.sv
module rs_framer_out_reg
  import rs_framer_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frm_ctl_t         ctl_i,
  input  logic [SYM_W-1:0] data_i,
  output frm_ctl_t         ctl_o,
  output logic [SYM_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o  <= '0;
      data_o <= '0;
    end else begin
      ctl_o <= ctl_i;
      if (ctl_i.valid) data_o <= data_i;
    end
  end
endmodule

// File: rtl/rs_framer.sv
module rs_framer
  import rs_framer_pkg::*;
#(
  parameter int SYM_W   = 8,
  parameter int MSG_LEN = 223,
  parameter int CW_LEN  = 255,
  localparam int POS_W  = $clog2(CW_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] src_data_i,
  input  logic             src_valid_i,
  output logic             src_ready_o,
  output logic [SYM_W-1:0] enc_data_o,
  output logic             enc_valid_o,
  output logic             enc_sop_o,
  output logic             enc_eop_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] MSG_END = POS_W'(MSG_LEN - 1);

  logic     msg_phase;
  logic     acc;
  frm_ctl_t ctl_d, ctl_q;

  assign acc = src_valid_i & msg_phase;

  rs_framer_pos_ctr #(.MSG_LEN(MSG_LEN), .CW_LEN(CW_LEN)) u_pos (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .pos_o      (pos_o),
    .msg_phase_o(msg_phase)
  );

  always_comb begin
    ctl_d.valid = acc;
    ctl_d.sop   = acc & (pos_o == '0);
    ctl_d.eop   = acc & (pos_o == MSG_END);
  end

  rs_framer_out_reg #(.SYM_W(SYM_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctl_i (ctl_d),
    .data_i(src_data_i),
    .ctl_o (ctl_q),
    .data_o(enc_data_o)
  );

  assign src_ready_o = msg_phase;
  assign enc_valid_o = ctl_q.valid;
  assign enc_sop_o   = ctl_q.sop;
  assign enc_eop_o   = ctl_q.eop;
endmodule

// File: rtl/rs_framer_chk.sv
module rs_framer_chk #(
  parameter int SYM_W   = 8,
  parameter int MSG_LEN = 223,
  parameter int CW_LEN  = 255,
  localparam int POS_W  = $clog2(CW_LEN)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SYM_W-1:0] src_data_i,
  input logic             src_valid_i,
  input logic             src_ready_o,
  input logic [SYM_W-1:0] enc_data_o,
  input logic             enc_valid_o,
  input logic             enc_sop_o,
  input logic             enc_eop_o,
  input logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] MSG_END = POS_W'(MSG_LEN - 1);
  localparam logic [POS_W-1:0] CW_END  = POS_W'(CW_LEN - 1);

  p_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && src_valid_i) |=> (enc_valid_o && enc_data_o == $past(src_data_i)));

  p_sop_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && src_valid_i && pos_o == '0) |=> enc_sop_o);

  p_eop_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && src_valid_i && pos_o == MSG_END) |=> enc_eop_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && !src_valid_i) |=> ($stable(pos_o) && !enc_valid_o));

  p_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_ready_o |=> (!enc_valid_o && $stable(enc_data_o)));

  p_adv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ready_o && pos_o != CW_END) |=> (pos_o == $past(pos_o) + POS_W'(1)));

  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o == CW_END) |=> (pos_o == '0));

  p_flags_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_sop_o || enc_eop_o) |-> (enc_valid_o && !(enc_sop_o && enc_eop_o)));
endmodule

bind rs_framer rs_framer_chk #(.SYM_W(SYM_W), .MSG_LEN(MSG_LEN), .CW_LEN(CW_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_data_i (src_data_i),
  .src_valid_i(src_valid_i),
  .src_ready_o(src_ready_o),
  .enc_data_o (enc_data_o),
  .enc_valid_o(enc_valid_o),
  .enc_sop_o  (enc_sop_o),
  .enc_eop_o  (enc_eop_o),
  .pos_o      (pos_o)
);

// File: tb/sim_rs_framer.sv
module sim_rs_framer;
  localparam int CLK_PERIOD = 10;
  localparam int MSG_LEN = 223;
  localparam int CW_LEN  = 255;
  localparam int PAR_LEN = CW_LEN - MSG_LEN;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] src_data_i = '0;
  logic       src_valid_i = 1'b0;
  logic       src_ready_o;
  logic [7:0] enc_data_o;
  logic       enc_valid_o, enc_sop_o, enc_eop_o;
  logic [7:0] pos_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rs_framer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_data_i(src_data_i), .src_valid_i(src_valid_i),
    .src_ready_o(src_ready_o), .enc_data_o(enc_data_o), .enc_valid_o(enc_valid_o),
    .enc_sop_o(enc_sop_o), .enc_eop_o(enc_eop_o), .pos_o(pos_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sym(input int pkt, input int i);
    return 8'((i * 7 + pkt * 13 + 1) & 255);
  endfunction

  // drive on falling edge, sample just after the rising edge that takes it
  task automatic drive(input logic v, input logic [7:0] d);
    @(negedge clk_i);
    src_valid_i = v;
    src_data_i  = d;
    @(posedge clk_i);
    #1;
  endtask

  task automatic flags_ok();
    chk("R9 sop/eop without valid or together",
        int'((enc_sop_o | enc_eop_o) & ~enc_valid_o) + int'(enc_sop_o & enc_eop_o), 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    src_valid_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 pos in reset", int'(pos_o), 0);
    chk("R1 ready in reset", int'(src_ready_o), 1);
    chk("R1 flags in reset", int'({enc_valid_o, enc_sop_o, enc_eop_o}), 0);
    chk("R1 data in reset", int'(enc_data_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R1 pos after reset", int'(pos_o), 0);
    chk("R1 valid after reset", int'(enc_valid_o), 0);
  endtask

  // message part; gap_mod > 0 inserts an idle edge before symbol i when i % gap_mod == 7 or i is last
  task automatic t_message(input int pkt, input int gap_mod);
    for (int i = 0; i < MSG_LEN; i++) begin
      if (gap_mod > 0 && ((i % gap_mod) == 7 || i == MSG_LEN - 1)) begin
        drive(1'b0, 8'h55);
        chk("R5 pos held on gap", int'(pos_o), i);
        chk("R5 flags low on gap", int'({enc_valid_o, enc_sop_o, enc_eop_o}), 0);
      end
      chk("R6 ready high in message part", int'(src_ready_o), 1);
      chk("R5 pos before symbol", int'(pos_o), i);
      drive(1'b1, sym(pkt, i));
      chk("R2 valid", int'(enc_valid_o), 1);
      chk("R2 data", int'(enc_data_o), int'(sym(pkt, i)));
      chk("R3 sop", int'(enc_sop_o), int'(i == 0));
      chk("R4 eop", int'(enc_eop_o), int'(i == MSG_LEN - 1));
      flags_ok();
    end
  endtask

  task automatic t_parity(input int pkt, input logic push);
    for (int k = 0; k < PAR_LEN; k++) begin
      chk("R6 ready low in parity", int'(src_ready_o), 0);
      chk("R7 pos in parity", int'(pos_o), MSG_LEN + k);
      drive(push, 8'hEE);
      chk("R6 valid ignored", int'(enc_valid_o), 0);
      chk("R6 data kept", int'(enc_data_o), int'(sym(pkt, MSG_LEN - 1)));
      chk("R7 pos step/wrap", int'(pos_o), (k == PAR_LEN - 1) ? 0 : MSG_LEN + k + 1);
    end
    chk("R7 ready back after wrap", int'(src_ready_o), 1);
  endtask

  task automatic t_idle_wrap(input int pkt);
    for (int j = 0; j < 5; j++) begin
      drive(1'b0, 8'h33);
      chk("R8 pos stays 0", int'(pos_o), 0);
      chk("R8 no sop while idle", int'(enc_sop_o | enc_valid_o), 0);
    end
    drive(1'b1, sym(pkt, 0));
    chk("R8 sop on next symbol", int'(enc_sop_o), 1);
    chk("R8 pos after first", int'(pos_o), 1);
  endtask

  task automatic t_mid_reset();
    for (int i = 0; i < 10; i++) drive(1'b1, sym(9, i));
    @(negedge clk_i);
    src_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset pos", int'(pos_o), 0);
    chk("R1 async reset flags", int'({enc_valid_o, enc_sop_o, enc_eop_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(1'b1, 8'hA5);
    chk("R3 sop after reset", int'(enc_sop_o), 1);
    chk("R2 data after reset", int'(enc_data_o), 8'hA5);
  endtask

  initial begin
    t_reset();
    t_message(0, 0);
    t_parity(0, 1'b1);
    t_message(1, 50);
    t_parity(1, 1'b0);
    t_idle_wrap(2);
    t_mid_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule